// File: doc/BRIEF.md
# Excess-3 Decimal Multiple Row Generator

This block builds one partial-product row for a parallel decimal multiplier. From a D-digit BCD multiplicand it forms the five positive multiples 1X to 5X at once. Each digit is an excess-3 code, so a digit's value is its code minus three. No carry ripples across the row. For every digit the biased product N·Xi+3 is split into a local digit and a transfer of 0 to 4. Each position then adds only the transfer from the position below it, so every multiple costs a single small addition per digit, whatever N is.

One recoded multiplier digit controls the row. A one-hot magnitude picks one of the five multiples, and a sign bit negates the chosen row by inverting every code bit. A zero magnitude gives an all-zero row. The row's bits are then passed on as digits of the overloaded set [0,15]. Alongside the row, the block emits a precomputed BCD correction constant. The reduction tree adds this constant to remove the excess-3 bias and, for a negative row, the nines'-complement offset. The row and its constant leave through registers, one clock after the inputs.

Top module: `dec_multiple_row`

## Requirements
- R1: The outputs are registered. The row and the correction for the inputs present at a rising clock edge appear after that edge and stay unchanged until the next edge. A synchronous active-high reset clears both outputs to zero.
- R2: For a positive row (sign 0, magnitude nonzero) every output digit code lies in [0,13], which is an excess-3 value in [-3,10].
- R3: Magnitude bit j (j = 0..4) selects the multiple (j+1)·X. At most one magnitude bit may be set.
- R4: For a positive row of multiple k, the sum over i of digit_i·10^i, plus the correction read as a BCD number, equals k·X modulo 10^(D+1).
- R5: For a negative row (sign 1) of multiple k, the same sum equals −k·X modulo 10^(D+1).
- R6: The positive 1X row has digit code Xi+3 at every position i < D and code 3 at position D.
- R7: For multiples 2X to 5X in the positive case, digit i has code ((N·Xi+3) mod 10) + floor((N·X(i−1)+3)/10), with the second term taken as 0 at i = 0. The top digit D has code 3 + floor((N·X(D−1)+3)/10). Each digit depends only on Xi and X(i−1).
- R8: With sign 1, each output digit code is 15 minus the code the same digit has with sign 0.
- R9: The correction is a (D+1)-digit BCD vector, with digit 0 in bits [3:0]. For a positive row its low digit is 7 and all other digits are 6. For a negative row its low digit is 8 and all other digits are 6.
- R10: With magnitude zero, both the row and the correction are all zero, whatever the values of X and the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_bcd | input | 4*DIGITS | Multiplicand, BCD, digit i in bits [4i+3:4i] |
| mag_sel | input | 5 | One-hot magnitude; bit j selects (j+1)X |
| neg | input | 1 | Negate the selected multiple |
| pp_digits | output | 4*(DIGITS+1) | Registered row, overloaded [0,15] digits |
| pp_fix | output | 4*(DIGITS+1) | Registered BCD correction constant for the row |

## Verification
The in-RTL assertions check on every cycle the behaviours that can be seen one digit at a time or from the control inputs alone. These are the code bounds of positive and negated rows, the zero row, the one-hot magnitude, the low digit of the correction, and the top digit of the 1X row. The arithmetic identity cannot be seen from one digit: a row plus its correction must equal ±k·X modulo 10^(D+1) for every k in [−5,5]. The bench's scenarios show this by decoding whole rows for several multiplicands, including all nines and digit patterns that produce transfers. They also show the exact per-digit transfer rule, the one-cycle register timing, and that X and the sign are ignored when the magnitude is zero.

// File: rtl/decrow_pkg.sv
package decrow_pkg;
  typedef logic [3:0] dcode_t;
  localparam dcode_t XS3_BIAS = 4'd3;
  localparam int unsigned NUM_MULT = 5;
endpackage

// File: rtl/dr_digit_split.sv
// Splits one biased digit product N*xi+3 into a local digit (0..9) and a
// transfer (0..4) that belongs to the next higher position.
module dr_digit_split #(
  parameter int unsigned MULT = 2
) (
  input  logic [3:0] xi,
  output logic [3:0] local_digit,
  output logic [2:0] xfer
);
  import decrow_pkg::*;
  logic [6:0] prod;

  always_comb begin
    prod = 7'(MULT) * {3'b000, xi} + {3'b000, XS3_BIAS};
    if (prod >= 7'd40)      xfer = 3'd4;
    else if (prod >= 7'd30) xfer = 3'd3;
    else if (prod >= 7'd20) xfer = 3'd2;
    else if (prod >= 7'd10) xfer = 3'd1;
    else                    xfer = 3'd0;
    local_digit = 4'(prod - 7'd10 * {4'b0000, xfer});
  end
endmodule

// File: rtl/dr_multiple.sv
// Carry-free excess-3 multiple N*X: D+1 digit codes.
module dr_multiple #(
  parameter int unsigned DIGITS = 16,
  parameter int unsigned MULT   = 1
) (
  input  logic [4*DIGITS-1:0]     x_bcd,
  output logic [4*(DIGITS+1)-1:0] codes
);
  import decrow_pkg::*;

  generate
    if (MULT == 1) begin : g_unit
      // Digits below ten never produce a transfer for the unit multiple.
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        assign codes[4*i +: 4] = x_bcd[4*i +: 4] + XS3_BIAS;
      end
      assign codes[4*DIGITS +: 4] = XS3_BIAS;
    end else begin : g_split
      logic [DIGITS-1:0][3:0] loc;
      logic [DIGITS-1:0][2:0] xf;
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        dr_digit_split #(.MULT(MULT)) u_split (
          .xi          (x_bcd[4*i +: 4]),
          .local_digit (loc[i]),
          .xfer        (xf[i])
        );
        if (i == 0) begin : g_low
          assign codes[3:0] = loc[0];
        end else begin : g_mid
          // Only the neighbour's transfer is absorbed: no ripple.
          assign codes[4*i +: 4] = loc[i] + {1'b0, xf[i-1]};
        end
      end
      assign codes[4*DIGITS +: 4] = XS3_BIAS + {1'b0, xf[DIGITS-1]};
    end
  endgenerate
endmodule

// File: rtl/dr_row_select.sv
// Picks one multiple, applies the sign, attaches the correction constant
// and registers the result.
module dr_row_select #(
  parameter int unsigned DIGITS = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [decrow_pkg::NUM_MULT-1:0][4*(DIGITS+1)-1:0] cand,
  input  logic [decrow_pkg::NUM_MULT-1:0]          mag_sel,
  input  logic                                     neg,
  output logic [4*(DIGITS+1)-1:0]                  pp_q,
  output logic [4*(DIGITS+1)-1:0]                  fix_q
);
  import decrow_pkg::*;
  localparam int unsigned W = 4 * (DIGITS + 1);

  function automatic logic [W-1:0] fix_const(input logic [3:0] low);
    logic [W-1:0] f;
    f = '0;
    for (int i = 0; i <= int'(DIGITS); i++)
      f[4*i +: 4] = (i == 0) ? low : 4'd6;
    return f;
  endfunction

  // Positive: undo the +3 bias on D+1 digits. Negative: undo the bias of
  // the inverted codes and add the one that completes the ten's complement.
  localparam logic [W-1:0] POS_FIX = fix_const(4'd7);
  localparam logic [W-1:0] NEG_FIX = fix_const(4'd8);

  logic [NUM_MULT-1:0][W-1:0] masked;
  logic [W-1:0] picked, row_d, fix_d;
  logic         active;

  generate
    for (genvar j = 0; j < NUM_MULT; j++) begin : g_mask
      assign masked[j] = cand[j] & {W{mag_sel[j]}};
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int j = 0; j < int'(NUM_MULT); j++)
      picked = picked | masked[j];
    active = |mag_sel;
    row_d  = active ? (neg ? ~picked : picked) : '0;
    fix_d  = active ? (neg ? NEG_FIX : POS_FIX) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_q  <= '0;
      fix_q <= '0;
    end else begin
      pp_q  <= row_d;
      fix_q <= fix_d;
    end
  end

  // Qualifies past-value checks until one real capture has happened.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mag_sel)); // R3

  AST_ZERO_ROW: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ($past(mag_sel) == '0) |-> (pp_q == '0 && fix_q == '0)); // R10

  AST_FIX_LOW: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ($past(mag_sel) != '0) |-> (fix_q[3:0] == ($past(neg) ? 4'd8 : 4'd7))); // R9

  AST_UNIT_TOP: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ($past(mag_sel) == 5'b00001 && !$past(neg)) |-> (pp_q[W-1 -: 4] == XS3_BIAS)); // R6

  generate
    for (genvar i = 0; i <= DIGITS; i++) begin : g_chk
      AST_POS_CODE_MAX: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(mag_sel) != '0 && !$past(neg)) |-> (pp_q[4*i +: 4] <= 4'd13)); // R2
      AST_NEG_CODE_MIN: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(mag_sel) != '0 && $past(neg)) |-> (pp_q[4*i +: 4] >= 4'd2)); // R8
    end
  endgenerate
endmodule

// File: rtl/dec_multiple_row.sv
module dec_multiple_row #(
  parameter int unsigned DIGITS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [4*DIGITS-1:0]       x_bcd,
  input  logic [4:0]                mag_sel,
  input  logic                      neg,
  output logic [4*(DIGITS+1)-1:0]   pp_digits,
  output logic [4*(DIGITS+1)-1:0]   pp_fix
);
  import decrow_pkg::*;
  localparam int unsigned W = 4 * (DIGITS + 1);

  logic [NUM_MULT-1:0][W-1:0] cand;

  generate
    for (genvar m = 0; m < NUM_MULT; m++) begin : g_mult
      dr_multiple #(.DIGITS(DIGITS), .MULT(m + 1)) u_mult (
        .x_bcd (x_bcd),
        .codes (cand[m])
      );
    end
  endgenerate

  dr_row_select #(.DIGITS(DIGITS)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .cand    (cand),
    .mag_sel (mag_sel),
    .neg     (neg),
    .pp_q    (pp_digits),
    .fix_q   (pp_fix)
  );
endmodule

// File: tb/dec_multiple_row_test.sv
`timescale 1ns/1ps
module dec_multiple_row_test;
  localparam int D = 16;
  localparam int W = 4 * (D + 1);
  localparam longint unsigned MODV = 64'd100000000000000000; // 10^(D+1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4*D-1:0] x_bcd = '0;
  logic [4:0] mag_sel = '0;
  logic neg = 1'b0;
  logic [W-1:0] pp_digits, pp_fix;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3A5F;

  always #2.5 clk = ~clk;

  dec_multiple_row #(.DIGITS(D)) uut (
    .clk(clk), .rst(rst), .x_bcd(x_bcd), .mag_sel(mag_sel), .neg(neg),
    .pp_digits(pp_digits), .pp_fix(pp_fix)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mag_of(input int m);
    return (m == 0) ? 5'b0 : 5'(1 << (m - 1));
  endfunction

  function automatic longint unsigned num_of(input logic [W-1:0] v, input int nd);
    longint unsigned s = 0, p = 1;
    for (int i = 0; i < nd; i++) begin
      s += longint'(v[4*i +: 4]) * p;
      p *= 10;
    end
    return s;
  endfunction

  // Expected row codes from R6, R7 and R8.
  function automatic logic [W-1:0] exp_row(input logic [4*D-1:0] x, input int n,
                                           input bit ng);
    logic [W-1:0] r;
    int xi, xp;
    for (int i = 0; i <= D; i++) begin
      int c;
      xi = (i < D) ? int'(x[4*i +: 4]) : 0;
      xp = (i > 0) ? int'(x[4*(i-1) +: 4]) : 0;
      if (n == 1) c = (i < D) ? xi + 3 : 3;
      else if (i == D) c = 3 + (n * xp + 3) / 10;
      else c = ((n * xi + 3) % 10) + ((i > 0) ? (n * xp + 3) / 10 : 0);
      r[4*i +: 4] = ng ? 4'(15 - c) : 4'(c);
    end
    return r;
  endfunction

  function automatic logic [4*D-1:0] next_x();
    logic [4*D-1:0] x;
    for (int i = 0; i < D; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x[4*i +: 4] = 4'(lfsr[7:0] % 10);
    end
    return x;
  endfunction

  task automatic apply(input logic [4*D-1:0] x, input int m, input bit ng);
    @(negedge clk);
    x_bcd = x; mag_sel = mag_of(m); neg = ng;
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    x_bcd = {D{4'h9}}; mag_sel = 5'b00100; neg = 1'b1;
    repeat (3) @(negedge clk);
    check(pp_digits == '0 && pp_fix == '0, "R1 reset clears outputs",
          {pp_digits, pp_fix}, 0);
    rst = 1'b0;
  endtask

  task automatic test_identity(input logic [4*D-1:0] x);
    longint unsigned xv = num_of({4'h0, x}, D);
    for (int k = -5; k <= 5; k++) begin
      longint unsigned got, want, mk;
      apply(x, (k < 0) ? -k : k, k < 0);
      got = (num_of(pp_digits, D + 1) + num_of(pp_fix, D + 1)) % MODV;
      mk = longint'((k < 0) ? -k : k) * xv;
      want = (k < 0) ? ((MODV - mk) % MODV) : mk;
      check(got == want, (k < 0) ? "R5 negative row value" : "R4 positive row value",
            got, want);
    end
  endtask

  task automatic test_digits(input logic [4*D-1:0] x);
    for (int n = 1; n <= 5; n++) begin
      apply(x, n, 1'b0);
      check(pp_digits == exp_row(x, n, 1'b0), (n == 1) ? "R6 unit row codes" :
            "R7 carry-free digit codes", pp_digits, exp_row(x, n, 1'b0));
      for (int i = 0; i <= D; i++)
        if (pp_digits[4*i +: 4] > 4'd13)
          check(1'b0, "R2 positive digit above 13", pp_digits[4*i +: 4], 13);
      apply(x, n, 1'b1);
      check(pp_digits == exp_row(x, n, 1'b1), "R8 inverted codes",
            pp_digits, exp_row(x, n, 1'b1));
    end
  endtask

  task automatic test_select();
    logic [4*D-1:0] x = next_x();
    for (int n = 1; n <= 5; n++) begin
      apply(x, n, 1'b0);
      check(pp_digits == exp_row(x, n, 1'b0), "R3 magnitude bit picks multiple",
            pp_digits, exp_row(x, n, 1'b0));
    end
  endtask

  task automatic test_fix();
    logic [W-1:0] pos_f, neg_f;
    for (int i = 0; i <= D; i++) begin
      pos_f[4*i +: 4] = (i == 0) ? 4'd7 : 4'd6;
      neg_f[4*i +: 4] = (i == 0) ? 4'd8 : 4'd6;
    end
    apply({D{4'h5}}, 3, 1'b0);
    check(pp_fix == pos_f, "R9 positive correction", pp_fix, pos_f);
    apply({D{4'h5}}, 3, 1'b1);
    check(pp_fix == neg_f, "R9 negative correction", pp_fix, neg_f);
  endtask

  task automatic test_zero();
    apply({D{4'h9}}, 0, 1'b1);
    check(pp_digits == '0 && pp_fix == '0, "R10 zero magnitude, sign 1",
          {pp_digits, pp_fix}, 0);
    apply(next_x(), 0, 1'b0);
    check(pp_digits == '0 && pp_fix == '0, "R10 zero magnitude, sign 0",
          {pp_digits, pp_fix}, 0);
  endtask

  task automatic test_timing();
    logic [4*D-1:0] xa = next_x();
    logic [4*D-1:0] xb = {D{4'h7}};
    apply(xa, 4, 1'b0);
    @(negedge clk);
    x_bcd = xb; mag_sel = mag_of(2); neg = 1'b1;
    #1;
    check(pp_digits == exp_row(xa, 4, 1'b0), "R1 output held before edge",
          pp_digits, exp_row(xa, 4, 1'b0));
    @(negedge clk);
    check(pp_digits == exp_row(xb, 2, 1'b1), "R1 output after one edge",
          pp_digits, exp_row(xb, 2, 1'b1));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    test_reset();
    test_timing();
    test_zero();
    test_fix();
    test_select();
    test_identity('0);
    test_identity({D{4'h9}});
    test_identity(64'h0123456789012345);
    test_digits({D{4'h9}});
    test_digits(64'h9876543210987654);
    for (int t = 0; t < 6; t++) begin
      logic [4*D-1:0] xr = next_x();
      test_identity(xr);
      test_digits(xr);
    end
    test_reset();
    done = 1'b1;
    finish_run();
  end
endmodule